// File: doc/BRIEF.md
# Timer Output Compare Channel Bank

A set of timer channels sharing one 16-bit free-running counter. Four channels are compare-only; a fifth, the dual channel, is either a compare channel or an input capture register, chosen by a mode bit. Every channel owns a 16-bit register and an equality comparator against the counter. When the two are equal, the channel's status flag is set and, for channels with an output pin, a programmed pin action is applied. The dual channel in capture mode latches the counter on a chosen edge of its capture pin instead.

Software programs pulses by writing the next match time into a channel register, so pin edges land on exact counter values whatever the bus latency. The interrupt output is the OR of every flag whose mask bit is set. A flat word-addressed register port, with a combinational read path, reaches all registers.

Top module: `tmr_cmp_bank`

## Requirements
- R1: The counter reads 0 after reset, increases by 1 on every clock and wraps from 16'hFFFF to 16'h0000; it is read at address 5, and bus writes to address 5 are ignored.
- R2: After reset every channel register (addresses 0 to 4) reads 16'hFFFF; flags, mask, action control, mode, all pins and irq_o are 0.
- R3: When the counter equals channel c's register (c = 0..4, dual channel is 4), flag bit c (address 6) reads 1 from the next clock on.
- R4: Writing address 6 clears each flag whose data bit is 1; a 0 bit leaves the flag unchanged; a match in the same cycle as a clear leaves the flag set.
- R5: irq_o is 1 exactly when some flag bit is 1 and the same bit of the mask register (address 7) is 1.
- R6: Channels 1, 2, 3 and 4 drive pin_o[0..3]; pin k takes its action from address 8 bits [2k+1:2k]: 00 hold, 01 toggle, 10 drive 0, 11 drive 1, applied on the clock edge of the match; without a match the pin holds.
- R7: A pin action is applied on every match, whether or not the channel's flag was cleared since the previous match.
- R8: Mode register (address 9) bit 0 = 1 puts the dual channel in capture mode; bit 1 enables rising and bit 2 falling edges of cap_pin_i; on an enabled edge the register at address 4 loads the counter value and flag bit 4 sets.
- R9: In capture mode bus writes to address 4 are ignored, the dual channel makes no compare match and pin_o[3] holds.
- R10: Addresses 0 to 4, 7, 8 and 9 read back the last value written, zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; counter advances every cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| cap_pin_i | input | 1 | Capture input of the dual channel |
| pin_o | output | 4 | Compare output pins of channels 1 to 4 |
| irq_o | output | 1 | Masked OR of all flags |

## Verification
Directed sequences drive one pin action twice without clearing its flag, separating per-match actions from flag-gated ones, and exercise the write-one-to-clear rules with zero and one data bits. Capture is tried on a rising edge and then with a bus write aimed at the captured register, telling a capture load from an ignored write. Random traffic writes compare values a few counts ahead of the counter, random action codes, masks, modes and capture-pin toggles across a full counter wrap, so matches of several channels in one cycle, set-versus-clear collisions and mode switches around pending edges are compared against a bench model on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pin_act_e;
endpackage

// File: rtl/tmr_free_cnt.sv
module tmr_free_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic en_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_i;
  end

  assign evt_o = en_i && ((rise_en_i && pin_i && !prev_q) ||
                          (fall_en_i && !pin_i && prev_q));

  p_evt_needs_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (pin_i != prev_q));
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter bit          HAS_PIN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cmp_en_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             cap_ld_i,
  input  logic             flag_clr_i,
  input  pin_act_e         act_i,
  output logic [CNT_W-1:0] val_o,
  output logic             flag_o,
  output logic             pin_o
);
  logic [CNT_W-1:0] val_q;
  logic             flag_q;
  logic             match;

  assign match = cmp_en_i && (val_q == cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       val_q <= '1;
    else if (cap_ld_i) val_q <= cnt_i;
    else if (wr_en_i)  val_q <= wr_data_i;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (match || cap_ld_i)  flag_q <= 1'b1;
    else if (flag_clr_i)         flag_q <= 1'b0;
  end

  assign val_o  = val_q;
  assign flag_o = flag_q;

  generate
    if (HAS_PIN) begin : g_pin
      logic pin_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pin_q <= 1'b0;
        else if (match) begin
          unique case (act_i)
            ACT_TOGGLE: pin_q <= ~pin_q;
            ACT_LOW:    pin_q <= 1'b0;
            ACT_HIGH:   pin_q <= 1'b1;
            default:    pin_q <= pin_q;
          endcase
        end
      end
      assign pin_o = pin_q;

      p_pin_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match && act_i == ACT_HIGH) |=> pin_q);
      p_pin_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match && act_i == ACT_LOW) |=> !pin_q);
      p_pin_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !match |=> $stable(pin_q));
      p_toggle_every_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match && act_i == ACT_TOGGLE) |=> pin_q != $past(pin_q));
    end else begin : g_nopin
      logic unused_act;
      assign unused_act = ^act_i;
      assign pin_o = 1'b0;
    end
  endgenerate

  p_match_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> flag_q);
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !match && !cap_ld_i) |=> !flag_q);
  p_cap_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ld_i |=> (val_q == $past(cnt_i)) && flag_q);
endmodule

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_OC = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned AW     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic              cap_pin_i,
  output logic [NUM_OC-1:0] pin_o,
  output logic              irq_o
);
  localparam int unsigned NUM_CH  = NUM_OC + 1;
  localparam int unsigned NUM_PIN = NUM_OC;
  localparam int unsigned DUAL    = NUM_OC;
  localparam int unsigned CTL_W   = 2 * NUM_PIN;
  localparam logic [AW-1:0] A_CNT = AW'(NUM_CH);
  localparam logic [AW-1:0] A_FLG = AW'(NUM_CH + 1);
  localparam logic [AW-1:0] A_MSK = AW'(NUM_CH + 2);
  localparam logic [AW-1:0] A_CTL = AW'(NUM_CH + 3);
  localparam logic [AW-1:0] A_MOD = AW'(NUM_CH + 4);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  vals [NUM_CH];
  logic [NUM_CH-1:0] flags;
  logic [NUM_CH-1:0] pins_w;
  logic [NUM_CH-1:0] mask_q;
  logic [CTL_W-1:0]  ctl_q;
  logic [2:0]        mode_q;
  logic              cap_mode;
  logic              cap_evt;
  logic [NUM_CH-1:0] clr_vec;

  assign cap_mode = mode_q[0];
  assign clr_vec  = (bus_we_i && bus_addr_i == A_FLG) ? bus_wdata_i[NUM_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      ctl_q  <= '0;
      mode_q <= '0;
    end else if (bus_we_i) begin
      if (bus_addr_i == A_MSK) mask_q <= bus_wdata_i[NUM_CH-1:0];
      if (bus_addr_i == A_CTL) ctl_q  <= bus_wdata_i[CTL_W-1:0];
      if (bus_addr_i == A_MOD) mode_q <= bus_wdata_i[2:0];
    end
  end

  tmr_free_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt)
  );

  tmr_edge_det u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (cap_pin_i),
    .en_i     (cap_mode),
    .rise_en_i(mode_q[1]),
    .fall_en_i(mode_q[2]),
    .evt_o    (cap_evt)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam bit IS_DUAL = (c == DUAL);
      pin_act_e act;
      logic     wr_en;
      logic     cmp_en;
      logic     cap_ld;

      if (c == 0) begin : g_act0
        assign act = ACT_HOLD;
      end else begin : g_actn
        assign act = pin_act_e'(ctl_q[2*(c-1) +: 2]);
      end

      assign cmp_en = !(IS_DUAL && cap_mode);
      assign wr_en  = bus_we_i && (bus_addr_i == AW'(c)) && cmp_en;
      assign cap_ld = IS_DUAL && cap_evt;

      tmr_cmp_chan #(.CNT_W(CNT_W), .HAS_PIN(c != 0)) u_ch (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cnt_i     (cnt),
        .cmp_en_i  (cmp_en),
        .wr_en_i   (wr_en),
        .wr_data_i (bus_wdata_i),
        .cap_ld_i  (cap_ld),
        .flag_clr_i(clr_vec[c]),
        .act_i     (act),
        .val_o     (vals[c]),
        .flag_o    (flags[c]),
        .pin_o     (pins_w[c])
      );
    end
  endgenerate

  logic unused_pin0;
  assign unused_pin0 = pins_w[0];
  assign pin_o       = pins_w[NUM_CH-1:1];
  assign irq_o       = |(flags & mask_q);

  always_comb begin
    bus_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr_i == AW'(c)) bus_rdata_o = vals[c];
    end
    if (bus_addr_i == A_CNT) bus_rdata_o = cnt;
    if (bus_addr_i == A_FLG) bus_rdata_o = CNT_W'(flags);
    if (bus_addr_i == A_MSK) bus_rdata_o = CNT_W'(mask_q);
    if (bus_addr_i == A_CTL) bus_rdata_o = CNT_W'(ctl_q);
    if (bus_addr_i == A_MOD) bus_rdata_o = CNT_W'(mode_q);
  end

  p_cap_wr_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode && bus_we_i && bus_addr_i == AW'(DUAL) && !cap_evt) |=> $stable(vals[DUAL]));
  p_cap_pin_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_mode |=> $stable(pin_o[NUM_PIN-1]));
  p_irq_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags == '0) |-> !irq_o);
endmodule

// File: tb/tmr_cmp_bank_bench.sv
`timescale 1ns/1ps
module tmr_cmp_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        cap = 1'b0;
  logic [3:0]  pins;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_cmp_bank u_tmr_cmp_bank (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cap_pin_i(cap),
    .pin_o(pins), .irq_o(irq)
  );

  // reference model built from the requirements
  logic [15:0] m_cmp [5];
  logic [15:0] m_cnt;
  logic [4:0]  m_flag, m_mask;
  logic [7:0]  m_ctl;
  logic [2:0]  m_mode;
  logic [3:0]  m_pin;
  logic        m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 5; c++) m_cmp[c] = 16'hFFFF;
      m_cnt = 0; m_flag = 0; m_mask = 0; m_ctl = 0; m_mode = 0; m_pin = 0; m_prev = 0;
    end else begin
      logic [4:0] hit;
      logic evt;
      logic [1:0] a;
      for (int c = 0; c < 5; c++)
        hit[c] = (m_cmp[c] == m_cnt) && !(c == 4 && m_mode[0]);
      evt = m_mode[0] && ((m_mode[1] && cap && !m_prev) || (m_mode[2] && !cap && m_prev));
      for (int k = 0; k < 4; k++) if (hit[k+1]) begin
        a = m_ctl[2*k +: 2];
        if (a == 2'b01) m_pin[k] = ~m_pin[k];
        else if (a == 2'b10) m_pin[k] = 1'b0;
        else if (a == 2'b11) m_pin[k] = 1'b1;
      end
      if (we && addr == 6) m_flag = m_flag & ~wdata[4:0];
      m_flag = m_flag | hit | {evt, 4'b0};
      if (we && addr < 4) m_cmp[addr] = wdata;
      if (we && addr == 4 && !m_mode[0]) m_cmp[4] = wdata;
      if (evt) m_cmp[4] = m_cnt;
      if (we && addr == 7) m_mask = wdata[4:0];
      if (we && addr == 8) m_ctl = wdata[7:0];
      if (we && addr == 9) m_mode = wdata[2:0];
      m_prev = cap;
      m_cnt = m_cnt + 1'b1;
    end
  end

  function automatic logic [15:0] mread(logic [3:0] a);
    case (a)
      0, 1, 2, 3, 4: return m_cmp[a];
      5: return m_cnt;
      6: return {11'd0, m_flag};
      7: return {11'd0, m_mask};
      8: return {8'd0, m_ctl};
      9: return {13'd0, m_mode};
      default: return 16'h0;
    endcase
  endfunction

  function automatic string atag(logic [3:0] a);
    case (a)
      5: return "R1 counter";
      6: return "R3 R4 flags";
      default: return "R10 readback";
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // outputs checked away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R6 pins", {12'd0, pins}, {12'd0, m_pin});
    chk("R5 irq", {15'd0, irq}, {15'd0, |(m_flag & m_mask)});
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_exp(logic [3:0] a, logic [15:0] exp, string tag);
    addr = a; #1; chk(tag, rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    void'($urandom(32'd4711));
    idle(3);
    rst_n = 1;
    // R2 reset state
    @(negedge clk);
    for (int a = 0; a < 5; a++) rd_exp(4'(a), 16'hFFFF, "R2 reset compare reg");
    for (int a = 6; a < 10; a++) rd_exp(4'(a), 16'h0000, "R2 reset control");
    chk("R2 reset pins", {12'd0, pins}, 16'h0);
    chk("R2 reset irq", {15'd0, irq}, 16'h0);
    // R1 counter step and read-only
    addr = 5; #1; c = rdata;
    @(negedge clk); rd_exp(5, c + 16'd1, "R1 counter step");
    wr(5, 16'h0000);
    rd_exp(5, m_cnt, "R1 counter write ignored");
    chk("R1 counter not cleared", {15'd0, rdata < 16'd3}, 16'd0);
    // R6/R7 toggle twice without clearing flag
    wr(8, 16'h0001);
    wr(1, m_cnt + 16'd6); idle(10);
    chk("R6 toggle first match", {15'd0, pins[0]}, 16'd1);
    rd_exp(6, 16'h0002, "R3 flag after match");
    wr(1, m_cnt + 16'd6); idle(10);
    chk("R7 toggle with flag still set", {15'd0, pins[0]}, 16'd0);
    // R4 write-one-to-clear
    wr(6, 16'h0000); rd_exp(6, 16'h0002, "R4 zero keeps flag");
    wr(6, 16'h0002); rd_exp(6, 16'h0000, "R4 one clears flag");
    // R5 masked interrupt
    wr(7, 16'h0004);
    wr(2, m_cnt + 16'd4); idle(8);
    chk("R5 irq on masked flag", {15'd0, irq}, 16'd1);
    wr(6, 16'h0004); idle(1);
    chk("R5 irq drops after clear", {15'd0, irq}, 16'd0);
    // R8 capture on rising edge
    wr(9, 16'h0003);
    @(negedge clk); cap = 1; c = m_cnt;
    @(negedge clk);
    rd_exp(4, c, "R8 captured counter");
    rd_exp(6, 16'h0010, "R8 capture flag");
    // R9 write ignored in capture mode
    wr(4, 16'h1234);
    rd_exp(4, c, "R9 write ignored in capture");
    wr(9, 16'h0000); wr(6, 16'h001F);
    // random phase across a full counter wrap
    for (int i = 0; i < 70000; i++) begin
      logic [3:0] a;
      int r;
      @(negedge clk);
      r = $urandom % 100;
      a = 4'($urandom % 10);
      we = (r < 35);
      addr = a;
      if (a < 5) wdata = m_cnt + 16'($urandom % 48);
      else if (a == 9) wdata = 16'($urandom % 8) & (($urandom % 4 == 0) ? 16'h7 : 16'h6);
      else wdata = 16'($urandom);
      if ($urandom % 10 == 0) cap = ~cap;
      #1; chk(atag(a), rdata, mread(a));
    end
    @(negedge clk); we = 0;
    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule